// File: doc/BRIEF.md
# Mutual Lifesign Window Watchdog

This block supervises a heartbeat shared by two chips on either side of an isolated link. It sends its own one-cycle heartbeat pulse at a fixed period, so the partner can run the same check on it. It also watches the partner's incoming heartbeat. Each incoming rising edge is compared against an acceptance window, measured in clock cycles since the last reference point. A pulse that arrives too early is an error. A window that expires with no pulse is also an error, and the window then starts again. Because of this, a partner held in reset shows up as a steady stream of timeouts. A partner whose oscillator has drifted far off shows up as early pulses or as timeouts.

A single error does not raise an alarm. The block reports a loss of communication only after a run of consecutive errors, two by default. It then raises a one-cycle event strobe and sets a sticky loss flag. The flag stays set until a write-one-to-clear input or a reset. A separate live status bit follows the health of the link from moment to moment: it drops on any error and comes back on the next valid pulse.

The incoming line is brought through a synchronizer and an edge detector. The window bounds come from inputs, so firmware or straps can tune them.

Top module: `lifesign_watchdog`

## Requirements
- R1: `tx_lifesign_o` is a single-cycle pulse, and successive rising edges are exactly `TX_PERIOD` cycles apart.
- R2: A rising edge on `rx_lifesign_i` counts as one received pulse, however long the line stays high. It passes through `SYNC_STAGES` (default 2) flops. A verdict on an edge driven just before clock edge E0 appears on the outputs after edge E0+`SYNC_STAGES`.
- R3: A received pulse whose spacing from the previous reference point is `n` cycles is valid when `win_min_i <= n <= win_max_i`. A pulse exactly at `win_max_i` is valid.
- R4: A received pulse with spacing below `win_min_i` is an early error. It becomes the new reference point.
- R5: When `win_max_i` cycles pass with no pulse, one timeout error is taken and the window restarts. A pulse with spacing `n` is therefore preceded by `(n-1)/win_max_i` timeouts and judged on the residue `n - k*win_max_i`.
- R6: `loss_evt_o` pulses for one cycle when the consecutive-error count reaches `ERR_LIMIT` (default 2). Further errors raise no new event until a valid pulse arrives.
- R7: A valid pulse resets the consecutive-error count to zero, so a single error after it raises no event.
- R8: `loss_flag_o` sets together with the event and stays set through later valid pulses. Only a high cycle on `loss_clr_i` or a reset clears it.
- R9: `link_ok_o` is 0 after reset, becomes 1 after a valid pulse and becomes 0 after any error.
- R10: During and right after reset, `tx_lifesign_o`, `loss_evt_o`, `loss_flag_o` and `link_ok_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_lifesign_i | input | 1 | Heartbeat line from the partner chip |
| win_min_i | input | CNT_W | Earliest accepted spacing in cycles |
| win_max_i | input | CNT_W | Latest accepted spacing in cycles; also the timeout |
| loss_clr_i | input | 1 | Write-one-to-clear for the sticky loss flag |
| tx_lifesign_o | output | 1 | Own heartbeat pulse to the partner |
| loss_evt_o | output | 1 | One-cycle loss-of-communication event |
| loss_flag_o | output | 1 | Sticky loss-of-communication flag |
| link_ok_o | output | 1 | Live link health |

## Verification
The assertions rely on three assumptions about the inputs:
- the window bounds satisfy `1 <= win_min_i <= win_max_i`;
- the bounds change only while reset is held;
- `TX_PERIOD` and `ERR_LIMIT` are at least 2, so a pulse or event can never occur on two adjacent cycles.

The bench changes bounds only under reset, for a wide window and for a degenerate window where minimum equals maximum. It sweeps the pulse spacing from below the minimum to several multiples of the maximum. It computes the expected timeout count, residue verdict, event count and flag state arithmetically from the spacing.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [1:0] {
    VERD_NONE    = 2'd0,
    VERD_VALID   = 2'd1,
    VERD_EARLY   = 2'd2,
    VERD_TIMEOUT = 2'd3
  } verdict_e;

endpackage

// File: rtl/lsw_tx_gen.sv
module lsw_tx_gen #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tx_o
);

  localparam int unsigned TW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          tx_q, tx_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + TW'(1);
    if (wrap) begin
      cnt_d = '0;
    end
    tx_d = wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tx_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tx_q  <= tx_d;
    end
  end

  assign tx_o = tx_q;

  assert_tx_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_q |=> !tx_q);

endmodule

// File: rtl/lsw_rx_sync.sv
module lsw_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o
);

  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = line_i;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], line_i};
    end
  endgenerate

  assign prev_d = sh_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;

  assert_rise_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/lsw_window.sv
module lsw_window
  import lsw_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] win_min_i,
  input  logic [CNT_W-1:0] win_max_i,
  output verdict_e         verdict_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  verdict_e         verdict;

  always_comb begin
    verdict = VERD_NONE;
    cnt_d   = cnt_q + ONE;
    if (rise_i) begin
      verdict = (cnt_q < win_min_i) ? VERD_EARLY : VERD_VALID;
      cnt_d   = ONE;
    end else if (cnt_q >= win_max_i) begin
      verdict = VERD_TIMEOUT;
      cnt_d   = ONE;
    end
  end

  assign cnt_en = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign verdict_o = verdict;

  // A timed-out window restarts, so the count never runs past the upper bound.
  assert_window_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= win_max_i);

  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict != VERD_NONE) |=> (cnt_q == ONE));

endmodule

// File: rtl/lsw_err_track.sv
module lsw_err_track
  import lsw_pkg::*;
#(
  parameter int unsigned ERR_LIMIT = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  verdict_e verdict_i,
  input  logic     clr_i,
  output logic     evt_o,
  output logic     flag_o,
  output logic     link_o
);

  localparam int unsigned CW = $clog2(ERR_LIMIT + 1);
  localparam logic [CW-1:0] LIM     = CW'(ERR_LIMIT);
  localparam logic [CW-1:0] LIM_M1  = CW'(ERR_LIMIT - 1);

  logic [CW-1:0] run_q, run_d;
  logic          evt_q, evt_d;
  logic          flag_q, flag_d;
  logic          link_q, link_d;
  logic          is_err, is_ok;

  assign is_err = (verdict_i == VERD_EARLY) || (verdict_i == VERD_TIMEOUT);
  assign is_ok  = (verdict_i == VERD_VALID);

  always_comb begin
    run_d  = run_q;
    evt_d  = 1'b0;
    flag_d = flag_q;
    link_d = link_q;
    if (is_ok) begin
      run_d  = '0;
      link_d = 1'b1;
    end else if (is_err) begin
      link_d = 1'b0;
      if (run_q < LIM) begin
        run_d = run_q + CW'(1);
      end
      evt_d = (run_q == LIM_M1);
    end
    if (evt_d) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
      link_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      evt_q  <= evt_d;
      flag_q <= flag_d;
      link_q <= link_d;
    end
  end

  assign evt_o  = evt_q;
  assign flag_o = flag_q;
  assign link_o = link_q;

  assert_evt_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);

  assert_evt_sets_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> flag_q);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(clr_i));

  assert_link_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_err |=> !link_q);

  assert_run_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ok |=> (run_q == '0) && !evt_q);

endmodule

// File: rtl/lifesign_watchdog.sv
module lifesign_watchdog
  import lsw_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TX_PERIOD   = 1000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ERR_LIMIT   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_lifesign_i,
  input  logic [CNT_W-1:0] win_min_i,
  input  logic [CNT_W-1:0] win_max_i,
  input  logic             loss_clr_i,
  output logic             tx_lifesign_o,
  output logic             loss_evt_o,
  output logic             loss_flag_o,
  output logic             link_ok_o
);

  logic     rx_rise;
  verdict_e verdict;

  lsw_tx_gen #(.PERIOD(TX_PERIOD)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tx_o   (tx_lifesign_o)
  );

  lsw_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (rx_lifesign_i),
    .rise_o (rx_rise)
  );

  lsw_window #(.CNT_W(CNT_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rx_rise),
    .win_min_i (win_min_i),
    .win_max_i (win_max_i),
    .verdict_o (verdict)
  );

  lsw_err_track #(.ERR_LIMIT(ERR_LIMIT)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .verdict_i (verdict),
    .clr_i     (loss_clr_i),
    .evt_o     (loss_evt_o),
    .flag_o    (loss_flag_o),
    .link_o    (link_ok_o)
  );

  assert_cfg_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_min_i <= win_max_i) && (win_min_i != '0));

endmodule

// File: tb/lifesign_watchdog_bench.sv
module lifesign_watchdog_bench;

  localparam int CW  = 8;
  localparam int PER = 10;
  localparam int LIM = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b0;
  logic          clr = 1'b0;
  logic [CW-1:0] wmin = 8'd6;
  logic [CW-1:0] wmax = 8'd9;
  logic          tx, evt, flag, link;

  int checks = 0, fails = 0;
  int ev_cnt = 0, ev_base = 0;
  int el = 0, cyc = 0, last_tx = -1;
  bit prev_tx = 1'b0, done = 1'b0;
  int run_m = 0, ev_m = 0;
  bit loss_m = 1'b0, link_m = 1'b0;

  always #5 clk = ~clk;

  lifesign_watchdog #(.CNT_W(CW), .TX_PERIOD(PER), .SYNC_STAGES(2), .ERR_LIMIT(LIM)) u_lifesign_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .rx_lifesign_i(rx), .win_min_i(wmin), .win_max_i(wmax),
    .loss_clr_i(clr), .tx_lifesign_o(tx), .loss_evt_o(evt), .loss_flag_o(flag), .link_ok_o(link));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R1: own heartbeat spacing and width
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      last_tx = -1;
      prev_tx = 1'b0;
    end else begin
      if (evt) ev_cnt++;
      if (tx && prev_tx) chk("R1 width", 2, 1);
      if (tx && !prev_tx) begin
        if (last_tx >= 0) chk("R1 period", cyc - last_tx, PER);
        last_tx = cyc;
      end
      prev_tx = tx;
    end
  end

  function automatic void m_err();
    link_m = 1'b0;
    if (run_m < LIM) begin
      run_m++;
      if (run_m == LIM) begin
        ev_m++;
        loss_m = 1'b1;
      end
    end
  endfunction

  // Rise after spacing n; verdict sampled three negedges later (R2 latency).
  task automatic step(input int n, input int hold, input bit check, input bit do_clr);
    int k, r;
    string tg;
    repeat (n - el) @(negedge clk);
    rx = 1'b1;
    el = 0;
    ev_m = 0;
    k = (n - 1) / int'(wmax);          // R5 timeouts before the pulse
    r = n - k * int'(wmax);
    repeat (k) m_err();
    if (r < int'(wmin)) m_err();       // R4 early
    else begin run_m = 0; link_m = 1'b1; end  // R3 valid, R7 run cleared
    tg = (r < int'(wmin)) ? "R4" : (k > 0) ? "R5" : "R3";
    for (int i = 1; i <= (do_clr ? 4 : 3); i++) begin
      @(negedge clk);
      el++;
      if (i == hold) rx = 1'b0;
      if (i == 3) begin
        #1;
        if (check) begin
          chk($sformatf("%s R9 link n=%0d", tg, n), int'(link), int'(link_m));
          chk($sformatf("%s %s events n=%0d", tg, (ev_m > 0 || run_m > 0) ? "R6" : "R7", n),
              ev_cnt - ev_base, ev_m);
          chk($sformatf("R8 flag n=%0d", n), int'(flag), int'(loss_m));
          if (hold == 3) chk($sformatf("R2 held line n=%0d", n), int'(link), int'(link_m));
        end
        ev_base = ev_cnt;
        if (do_clr) clr = 1'b1;
      end
      if (i == 4) begin
        clr = 1'b0;
        #1;
        chk("R8 clear", int'(flag), 0);
        loss_m = 1'b0;
      end
    end
  endtask

  task automatic run_cfg(input int mn, input int mx, input int nlo, input int nhi);
    rst_n = 1'b0;
    wmin = CW'(mn);
    wmax = CW'(mx);
    repeat (3) @(negedge clk);
    #1;
    chk("R10 link", int'(link), 0);
    chk("R10 flag", int'(flag), 0);
    chk("R10 evt", int'(evt), 0);
    chk("R10 tx", int'(tx), 0);
    @(negedge clk);
    rst_n = 1'b1;
    el = 0;
    step(2, 1, 1'b0, 1'b0);
    step(mx, 1, 1'b0, 1'b1);
    run_m = 0; link_m = 1'b1; loss_m = 1'b0;
    ev_base = ev_cnt;
    for (int n = nlo; n <= nhi; n++) begin
      step(n, (n % 5 == 0) ? 3 : 1, 1'b1, (n >= 5) && (n % 3 == 0) && loss_m);
      if (n % 4 == 1) step(mx, 1, 1'b1, 1'b0);   // R8 sticky across a valid pulse
    end
  endtask

  initial begin
    run_cfg(6, 9, 4, 30);
    run_cfg(5, 5, 4, 17);
    repeat (3 * PER) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule